// File: doc/BRIEF.md
# Mode-Selected Four-Bit ALU

This block is a small arithmetic and logic unit. It takes two 4-bit operands, a mode bit and a 2-bit function code, and returns a 4-bit result and a carry-out. One ripple-carry adder does all eight operations. A conditioning stage in front of the adder turns the two operands into two adder inputs, X and Y, and an initial carry C0.

In arithmetic mode X is always operand A. The stage then picks Y from operand B and sets C0, and this choice gives decrement, add, subtract or increment. In logic mode the stage forms the logic result itself and sends it through the adder as X. Y and C0 are both held at zero, so the result comes out unchanged and the carry is zero.

The AND and OR gates in the logic path are built as three-input majority functions. One input of each is tied low for AND and high for OR. By default the result and carry are registered once at the output. A parameter can instead make the whole path combinational.

Top module: `mode_alu4`

## Requirements
- R1: When `arith_mode` is 1 the block does the arithmetic operation that `fn_sel` picks. When it is 0 the block does the logic operation that `fn_sel` picks.
- R2: Arithmetic with `fn_sel`=00 gives `res` = (A-1) mod 16. `cout` is 1 exactly when A is not zero.
- R3: Arithmetic with `fn_sel`=01 gives `res` = (A+B) mod 16. `cout` is bit 4 of A+B.
- R4: Arithmetic with `fn_sel`=10 gives `res` = (A-B) mod 16. `cout` is 1 exactly when A >= B, with both read as unsigned numbers.
- R5: Arithmetic with `fn_sel`=11 gives `res` = (A+1) mod 16. `cout` is 1 exactly when A is 15.
- R6: Logic with `fn_sel`=00 gives `res` = bitwise NOT of A.
- R7: Logic with `fn_sel`=01 gives A AND B. Logic with `fn_sel`=11 gives A OR B. Both gates are majority functions with one tied input.
- R8: Logic with `fn_sel`=10 gives `res` = A, unchanged.
- R9: In arithmetic mode the adder inputs are set as follows. X equals A. C0 equals bit 1 of `fn_sel`. Each Y bit depends only on `fn_sel` and the B bit in the same position: it is 1 for code 00, B for 01, NOT B for 10, and 0 for 11.
- R10: In logic mode Y and C0 are zero, and `cout` is always 0.
- R11: With `REG_OUT`=1, `res` and `cout` show the operation presented before a rising clock edge once that edge has passed. While `rst_n` is low both outputs are 0.
- R12: The adder is a chain of four full adders. Each carry feeds the next higher bit, starting at bit 0. The 5-bit value {cout, sum} equals X+Y+C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset; clears the output register |
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| arith_mode | input | 1 | 1 = arithmetic, 0 = logic |
| fn_sel | input | 2 | Function code within the mode |
| res | output | 4 | Result |
| cout | output | 1 | Carry out of bit 3 |

## Verification
The outputs are registered, so each result is due one rising edge after its operands are driven on a falling edge. The driver pushes the expected result and carry into a queue at the moment it drives. The monitor pops one item a short delay after each rising edge, so it compares each output exactly one edge after its stimulus. All combinations of operands, mode and function code are driven twice, once in ascending and once in descending order, so each operation is reached from many different previous states. The outputs are also checked while reset is held with nonzero operands applied.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [1:0] {
    AR_DEC = 2'b00,
    AR_ADD = 2'b01,
    AR_SUB = 2'b10,
    AR_INC = 2'b11
  } arith_fn_e;

  typedef enum logic [1:0] {
    LG_NOT = 2'b00,
    LG_AND = 2'b01,
    LG_PASS = 2'b10,
    LG_OR  = 2'b11
  } logic_fn_e;

  // Three-input majority vote
  function automatic logic maj3(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction

  // Adder Y bit in arithmetic mode, from the function code and one B bit
  function automatic logic y_cond_bit(input logic [1:0] fs, input logic bb);
    logic yb;
    unique case (fs)
      AR_DEC:  yb = 1'b1;
      AR_ADD:  yb = bb;
      AR_SUB:  yb = ~bb;
      default: yb = 1'b0;
    endcase
    return yb;
  endfunction

  // Initial carry in arithmetic mode: set for subtract and increment
  function automatic logic c0_cond(input logic [1:0] fs);
    return fs[1];
  endfunction

  // Logic result for one bit
  function automatic logic logic_bit(input logic [1:0] fs, input logic ab, input logic bb);
    logic lb;
    unique case (fs)
      LG_NOT:  lb = ~ab;
      LG_AND:  lb = maj3(ab, bb, 1'b0);
      LG_PASS: lb = ab;
      default: lb = maj3(ab, bb, 1'b1);
    endcase
    return lb;
  endfunction

endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
  input  logic in_p,
  input  logic in_q,
  input  logic cin,
  output logic sum,
  output logic cy
);
  import alu4_pkg::*;

  assign sum = in_p ^ in_q ^ cin;
  assign cy  = maj3(in_p, in_q, cin);
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x_op,
  input  logic [W-1:0] y_op,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out
);
  localparam int CW = W + 1;

  // Carry chain brought out as a named vector
  logic [CW-1:0] carry_chain;

  assign carry_chain[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_stage
    alu_fa_cell u_fa (
      .in_p (x_op[i]),
      .in_q (y_op[i]),
      .cin  (carry_chain[i]),
      .sum  (sum[i]),
      .cy   (carry_chain[i+1])
    );
  end

  assign c_out = carry_chain[W];

  // R12
  sum_matches_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {c_out, sum} == ({1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, c_in}));

endmodule

// File: rtl/alu_cond.sv
module alu_cond #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         arith,
  input  logic [1:0]   fs,
  output logic [W-1:0] x_op,
  output logic [W-1:0] y_op,
  output logic         c0
);
  import alu4_pkg::*;

  logic [W-1:0] logic_res;
  logic [W-1:0] y_arith;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign logic_res[i] = logic_bit(fs, a[i], b[i]);
    assign y_arith[i]   = y_cond_bit(fs, b[i]);
  end

  always_comb begin
    if (arith) begin
      x_op = a;
      y_op = y_arith;
      c0   = c0_cond(fs);
    end else begin
      x_op = logic_res;
      y_op = '0;
      c0   = 1'b0;
    end
  end

  // R9
  arith_x_is_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arith |-> (x_op == a));

  // R9
  arith_c0_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arith |-> (c0 == fs[1]));

  // R10
  logic_y_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arith |-> (y_op == '0 && c0 == 1'b0));

  // R7
  logic_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arith && fs == 2'b01) |-> (x_op == (a & b)));

  // R7
  logic_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arith && fs == 2'b11) |-> (x_op == (a | b)));

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sum_in,
  input  logic         cy_in,
  output logic [W-1:0] res,
  output logic         cout
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res  <= '0;
        cout <= 1'b0;
      end else begin
        res  <= sum_in;
        cout <= cy_in;
      end
    end

    // R11
    reg_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (res == $past(sum_in) && cout == $past(cy_in)));
  end else begin : g_comb
    assign res  = sum_in;
    assign cout = cy_in;
  end

  // R11
  reset_zero_chk: assert property (@(posedge clk)
    (REG_OUT && !rst_n) |-> (res == '0 && cout == 1'b0));

endmodule

// File: rtl/mode_alu4.sv
module mode_alu4 #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         arith_mode,
  input  logic [1:0]   fn_sel,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W-1:0] x_op;
  logic [W-1:0] y_op;
  logic         c0;
  logic [W-1:0] add_sum;
  logic         add_cy;

  alu_cond #(.W(W)) u_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (op_a),
    .b     (op_b),
    .arith (arith_mode),
    .fs    (fn_sel),
    .x_op  (x_op),
    .y_op  (y_op),
    .c0    (c0)
  );

  alu_ripple #(.W(W)) u_add (
    .clk   (clk),
    .rst_n (rst_n),
    .x_op  (x_op),
    .y_op  (y_op),
    .c_in  (c0),
    .sum   (add_sum),
    .c_out (add_cy)
  );

  alu_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .sum_in (add_sum),
    .cy_in  (add_cy),
    .res    (res),
    .cout   (cout)
  );

  // R10
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arith_mode |-> !add_cy);

  // R4
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_mode && fn_sel == 2'b10) |-> (add_cy == (op_a >= op_b)));

endmodule

// File: tb/sim_mode_alu4.sv
`timescale 1ns/1ps
module sim_mode_alu4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic       arith_mode = 1'b0;
  logic [1:0] fn_sel = '0;
  logic [3:0] res;
  logic       cout;

  always #2.5 clk = ~clk;

  mode_alu4 u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .arith_mode(arith_mode), .fn_sel(fn_sel), .res(res), .cout(cout)
  );

  typedef struct packed {
    logic [3:0] a;
    logic [3:0] b;
    logic       m;
    logic [1:0] f;
    logic [3:0] er;
    logic       ec;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit drv_done = 1'b0;
  bit mon_on = 1'b0;

  // Reference: integer arithmetic, not a gate model
  function automatic logic [4:0] ref_calc(input logic [3:0] a, input logic [3:0] b,
                                          input logic m, input logic [1:0] f);
    int ai, bi, t;
    ai = a; bi = b;
    if (m) begin
      case (f)
        2'd0: t = ai + 15;
        2'd1: t = ai + bi;
        2'd2: t = ai - bi + 16;
        default: t = ai + 1;
      endcase
      return t[4:0];
    end
    case (f)
      2'd0: return {1'b0, ~a};
      2'd1: return {1'b0, a & b};
      2'd2: return {1'b0, a};
      default: return {1'b0, a | b};
    endcase
  endfunction

  function automatic string tag_of(input logic m, input logic [1:0] f);
    if (m) begin
      case (f)
        2'd0: return "R1 R2 R9 R12";
        2'd1: return "R1 R3 R9 R12";
        2'd2: return "R1 R4 R9 R12";
        default: return "R1 R5 R9 R12";
      endcase
    end
    case (f)
      2'd0: return "R1 R6 R10";
      2'd1: return "R1 R7 R10";
      2'd2: return "R1 R8 R10";
      default: return "R1 R7 R10";
    endcase
  endfunction

  task automatic drive(input logic [3:0] a, input logic [3:0] b,
                       input logic m, input logic [1:0] f);
    item_t it;
    logic [4:0] e;
    @(negedge clk);
    op_a = a; op_b = b; arith_mode = m; fn_sel = f;
    e = ref_calc(a, b, m, f);
    it.a = a; it.b = b; it.m = m; it.f = f; it.er = e[3:0]; it.ec = e[4];
    q.push_back(it);
  endtask

  // Monitor: output due one rising edge after the stimulus (R11)
  always @(posedge clk) begin
    #1;
    if (mon_on && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (res !== it.er || cout !== it.ec) begin
        n_bad++;
        $display("FAIL %s a=%0d b=%0d m=%0b f=%0d: got res=%0d cout=%0b, expected res=%0d cout=%0b",
                 tag_of(it.m, it.f), it.a, it.b, it.m, it.f, res, cout, it.er, it.ec);
      end
    end
  end

  task automatic reset_check(input string what);
    n_cmp++;
    if (res !== 4'd0 || cout !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 %s: got res=%0d cout=%0b, expected res=0 cout=0", what, res, cout);
    end
  endtask

  initial begin
    // Reset held with nonzero operands: outputs stay zero (R11)
    op_a = 4'd9; op_b = 4'd9; arith_mode = 1'b1; fn_sel = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    reset_check("during reset with 9+9 applied");
    op_a = 4'd15; fn_sel = 2'b11;
    @(negedge clk);
    reset_check("during reset with 15+1 applied");
    rst_n = 1'b1;
    mon_on = 1'b1;
    // Ascending pass over every combination
    for (int i = 0; i < 2048; i++) begin
      logic [10:0] v;
      v = i[10:0];
      drive(v[3:0], v[7:4], v[10], v[9:8]);
    end
    // Descending pass, so each operation follows different predecessors
    for (int i = 2047; i >= 0; i--) begin
      logic [10:0] v;
      v = i[10:0];
      drive(v[7:4], v[3:0], v[8], {v[10], v[9]});
    end
    repeat (3) @(negedge clk);
    drv_done = 1'b1;
  end

  initial begin
    fork
      wait (drv_done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule